// File: doc/BRIEF.md
# Operand Effective Address Unit

This block resolves the operand of one accumulator-style instruction. The caller presents a 4-bit mode code, a 16-bit address field, a register selector and the current program counter, and pulses `start`. The unit computes the effective address for that mode. When the mode needs memory, it issues one or two word reads on a simple request/ready port. It then returns the operand together with a single-cycle `done` pulse.

Nine modes are resolved:

- **Immediate:** the address field is the operand.
- **Register:** the operand is a register's content.
- **Direct:** one read at the address field.
- **Indirect:** one read at the address field returns a pointer, and a second read at that pointer returns the operand.
- **Register-indirect:** one read at the register's content.
- **Displacement:** one read at the address field plus the register.
- **Relative:** one read at the address field plus the program counter.
- **Indexed:** one read at the address field plus the register, after which the register is incremented.
- **Stack:** one read at the stack pointer.

The eight general registers and the dedicated stack pointer live inside the unit. They are loaded through a write port. Any undefined mode code completes at once with an error flag.

Top module: `operand_ea_unit`

## Requirements
- R1: After reset `done`, `err`, `mem_req` and `busy` are low and every general register reads as zero.
- R2: Mode code 0 (immediate) returns `addr_a` as the operand, makes no memory read and raises `done` on the first clock edge after `start`.
- R3: Mode code 1 (direct) makes exactly one read, at `addr_a`, and returns the read word.
- R4: Mode code 2 (indirect) reads at `addr_a`, then reads at the word returned, and returns the second word; exactly two reads occur.
- R5: Mode code 3 (register) returns general register `reg_sel` with no memory read and `done` one edge after `start`. A write with `rf_we` and `rf_wsel` 0 to 7 loads that general register.
- R6: Mode code 4 (register-indirect) makes one read at the content of register `reg_sel`.
- R7: Mode code 5 (displacement) makes one read at `addr_a` plus register `reg_sel`, modulo 2^16.
- R8: Mode code 6 (relative) makes one read at `addr_a` plus `pc`, modulo 2^16.
- R9: Mode code 7 (indexed) makes one read at `addr_a` plus register `reg_sel`. After that read the register holds its old value plus one, modulo 2^16.
- R10: Mode code 8 (stack) makes one read at the stack pointer, whatever `addr_a` and `reg_sel` are. `rf_wsel` value 8 loads the stack pointer.
- R11: Mode codes 9 to 15 raise `err` together with `done` one edge after `start`, make no read and leave `operand` unchanged.
- R12: While `mem_req` is high and `mem_ready` is low, the request and its address stay unchanged. A read completes in the cycle where both are high. `done` lasts exactly one cycle.
- R13: A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving an operand (taken when idle) |
| mode | input | 4 | Addressing mode code |
| addr_a | input | 16 | Address field of the instruction |
| reg_sel | input | 3 | General register selector |
| pc | input | 16 | Current program counter |
| rf_we | input | 1 | Register load strobe |
| rf_wsel | input | 4 | Register to load: 0-7 general, 8 stack pointer |
| rf_wdata | input | 16 | Value to load |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the read this cycle |
| busy | output | 1 | A resolution is in progress |
| done | output | 1 | One-cycle pulse, operand valid |
| err | output | 1 | Undefined mode, pulsed with `done` |
| operand | output | 16 | Resolved operand |

## Verification
Count the clock edges from the one that takes `start`:

- Modes that need no memory and undefined codes complete on that same edge.
- Single-read modes complete on edge 2+w, where the memory holds off `mem_ready` for w cycles of each request.
- Indirect mode completes on edge 3+2w.

The bench drives every input at the falling edge and counts falling edges until `done`, and it fails any run whose count differs from that formula. It sweeps every mode code, every register and several address values under wait states of 0, 1 and 2. For each run it compares the operand, the error flag, the number of reads and the address of each read with values computed from a register model kept in the bench.

// File: rtl/operand_ea_unit.sv
module operand_ea_unit #(
  parameter int W = 16,
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [W-1:0]  addr_a,
  input  logic [RW-1:0] reg_sel,
  input  logic [W-1:0]  pc,
  input  logic          rf_we,
  input  logic [RW:0]   rf_wsel,
  input  logic [W-1:0]  rf_wdata,
  output logic          mem_req,
  output logic [W-1:0]  mem_addr,
  input  logic [W-1:0]  mem_rdata,
  input  logic          mem_ready,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [W-1:0]  operand
);

  localparam logic [3:0] MD_IMM  = 4'd0;
  localparam logic [3:0] MD_DIR  = 4'd1;
  localparam logic [3:0] MD_IND  = 4'd2;
  localparam logic [3:0] MD_REG  = 4'd3;
  localparam logic [3:0] MD_RIND = 4'd4;
  localparam logic [3:0] MD_DISP = 4'd5;
  localparam logic [3:0] MD_REL  = 4'd6;
  localparam logic [3:0] MD_INDX = 4'd7;
  localparam logic [3:0] MD_STK  = 4'd8;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_RD1, S_RD2} st_t;

  st_t           st;
  logic [W-1:0]  rf [NREG];
  logic [W-1:0]  sp;
  logic          second_rd;
  logic          post_inc;
  logic [RW-1:0] inc_sel;
  logic [W-1:0]  ea;
  logic          needs_mem;

  wire [W-1:0] rval = rf[reg_sel];
  wire         bad  = mode > MD_STK;

  assign busy = st != S_IDLE;

  always_comb begin
    ea = addr_a;
    needs_mem = 1'b1;
    case (mode)
      MD_IMM, MD_REG:   needs_mem = 1'b0;
      MD_RIND:          ea = rval;
      MD_DISP, MD_INDX: ea = addr_a + rval;
      MD_REL:           ea = addr_a + pc;
      MD_STK:           ea = sp;
      MD_DIR, MD_IND:   ea = addr_a;
      default:          needs_mem = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      operand   <= '0;
      second_rd <= 1'b0;
      post_inc  <= 1'b0;
      inc_sel   <= '0;
      sp        <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (rf_we) begin
        if (!rf_wsel[RW]) rf[rf_wsel[RW-1:0]] <= rf_wdata;
        else if (rf_wsel[RW-1:0] == '0) sp <= rf_wdata;
      end
      case (st)
        S_IDLE: if (start) begin
          if (bad) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else if (!needs_mem) begin
            done    <= 1'b1;
            operand <= (mode == MD_IMM) ? addr_a : rval;
          end else begin
            mem_req   <= 1'b1;
            mem_addr  <= ea;
            second_rd <= mode == MD_IND;
            post_inc  <= mode == MD_INDX;
            inc_sel   <= reg_sel;
            st        <= S_RD1;
          end
        end
        S_RD1: if (mem_ready) begin
          if (second_rd) begin
            mem_addr <= mem_rdata;
            st       <= S_RD2;
          end else begin
            operand <= mem_rdata;
            done    <= 1'b1;
            mem_req <= 1'b0;
            st      <= S_IDLE;
            if (post_inc) rf[inc_sel] <= rf[inc_sel] + ONE;
          end
        end
        S_RD2: if (mem_ready) begin
          operand <= mem_rdata;
          done    <= 1'b1;
          mem_req <= 1'b0;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module operand_ea_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [3:0]   mode,
  input logic [W-1:0] addr_a,
  input logic         mem_req,
  input logic [W-1:0] mem_addr,
  input logic         mem_ready,
  input logic         busy,
  input logic         done,
  input logic         err,
  input logic [W-1:0] operand
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_req && !busy)); // R12

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R11

  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode > 4'd8) |=> (err && done && !mem_req && $stable(operand))); // R11

  AST_IMM_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 4'd0) |=> (done && !mem_req && operand == $past(addr_a))); // R2

  AST_REG_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 4'd3) |=> (done && !mem_req)); // R5

  AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (mode == 4'd1 || mode == 4'd2)) |=> (mem_req && mem_addr == $past(addr_a))); // R3

endmodule

bind operand_ea_unit operand_ea_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .addr_a(addr_a),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
  .busy(busy), .done(done), .err(err), .operand(operand)
);

// File: tb/operand_ea_unit_tb.sv
module operand_ea_unit_tb;

  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    mode = '0;
  logic [W-1:0]  addr_a = '0;
  logic [2:0]    reg_sel = '0;
  logic [W-1:0]  pc = '0;
  logic          rf_we = 1'b0;
  logic [3:0]    rf_wsel = '0;
  logic [W-1:0]  rf_wdata = '0;
  logic          mem_req;
  logic [W-1:0]  mem_addr;
  logic [W-1:0]  mem_rdata;
  logic          mem_ready;
  logic          busy, done, err;
  logic [W-1:0]  operand;

  always #5 clk = ~clk;

  operand_ea_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .addr_a(addr_a),
    .reg_sel(reg_sel), .pc(pc), .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .err(err), .operand(operand)
  );

  function automatic logic [W-1:0] memf(input logic [W-1:0] a);
    memf = (a * 16'd7) + 16'h1234;
  endfunction

  int         wait_cfg = 0;
  logic [3:0] wcnt = '0;
  int         nreads = 0;
  logic [W-1:0] rd_log [64];

  assign mem_ready = mem_req && (wcnt == wait_cfg[3:0]);
  assign mem_rdata = mem_ready ? memf(mem_addr) : '0;

  always @(posedge clk) begin
    if (mem_req && !mem_ready) wcnt <= wcnt + 4'd1;
    else wcnt <= '0;
    if (mem_req && mem_ready) begin
      rd_log[nreads[5:0]] <= mem_addr;
      nreads <= nreads + 1;
    end
  end

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [W-1:0] breg [8];
  logic [W-1:0] bsp;
  logic [W-1:0] last_op = '0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wr_reg(input logic [3:0] sel, input logic [W-1:0] val);
    @(negedge clk);
    rf_we = 1'b1; rf_wsel = sel; rf_wdata = val;
    @(negedge clk);
    rf_we = 1'b0;
    if (sel < 4'd8) breg[sel[2:0]] = val;
    else if (sel == 4'd8) bsp = val;
  endtask

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd0: tag_of = "R2";
      4'd1: tag_of = "R3";
      4'd2: tag_of = "R4";
      4'd3: tag_of = "R5";
      4'd4: tag_of = "R6";
      4'd5: tag_of = "R7";
      4'd6: tag_of = "R8";
      4'd7: tag_of = "R9";
      4'd8: tag_of = "R10";
      default: tag_of = "R11";
    endcase
  endfunction

  task automatic run(input logic [3:0] m, input logic [W-1:0] a, input logic [2:0] r,
                     input logic [W-1:0] p, input bit poke);
    logic [W-1:0] eop, ea0, ea1;
    int ereads, elat, n, base;
    bit eerr;
    string t;
    t = tag_of(m);
    eerr = 1'b0; ereads = 1; ea1 = '0;
    ea0 = a;
    case (m)
      4'd0: begin eop = a; ereads = 0; end
      4'd1: ea0 = a;
      4'd2: ea0 = a;
      4'd3: begin eop = breg[r]; ereads = 0; end
      4'd4: ea0 = breg[r];
      4'd5, 4'd7: ea0 = a + breg[r];
      4'd6: ea0 = a + p;
      4'd8: ea0 = bsp;
      default: begin eerr = 1'b1; eop = last_op; ereads = 0; end
    endcase
    if (m == 4'd2) begin
      ea1 = memf(ea0);
      eop = memf(ea1);
      ereads = 2;
    end else if (ereads == 1) eop = memf(ea0);
    elat = (ereads == 0) ? 1 : (ereads == 1 ? 2 + wait_cfg : 3 + 2 * wait_cfg);

    @(negedge clk);
    base = nreads;
    start = 1'b1; mode = m; addr_a = a; reg_sel = r; pc = p;
    n = 0;
    while (n < 60) begin
      @(negedge clk);
      n++;
      if (poke && busy && n < 3) begin
        start = 1'b1; mode = 4'd0; addr_a = 16'hdead;
      end else start = 1'b0;
      if (done) break;
    end
    start = 1'b0;
    chk(done === 1'b1, t, "done seen", done, 1);
    chk(n == elat, t, "latency", n, elat);
    chk(operand === eop, t, "operand", operand, eop);
    chk(err === eerr, eerr ? "R11" : t, "err", err, eerr);
    chk(nreads - base == ereads, t, "read count", nreads - base, ereads);
    if (ereads >= 1) chk(rd_log[base[5:0]] === ea0, t, "first read addr", rd_log[base[5:0]], ea0);
    if (ereads == 2) chk(rd_log[base[5:0] + 6'd1] === ea1, "R4", "pointer read addr", rd_log[base[5:0] + 6'd1], ea1);
    last_op = operand;
    if (m == 4'd7) breg[r] = breg[r] + 16'd1;
  endtask

  initial begin
    automatic logic [W-1:0] avals [4] = '{16'h0000, 16'hfffe, 16'h0123, 16'h8000};
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done === 1'b0, "R1", "done after reset", done, 0);
    chk(err === 1'b0, "R1", "err after reset", err, 0);
    chk(mem_req === 1'b0, "R1", "mem_req after reset", mem_req, 0);
    chk(busy === 1'b0, "R1", "busy after reset", busy, 0);
    for (int i = 0; i < 8; i++) breg[i] = '0;
    bsp = '0;
    for (int i = 0; i < 8; i++) run(4'd3, 16'h0, 3'(i), 16'h0, 1'b0); // R1 registers zero

    for (int i = 0; i < 7; i++) wr_reg(4'(i), 16'(i * 16'h1111 + 16'h0042)); // R5 load
    wr_reg(4'd7, 16'hffff);
    wr_reg(4'd8, 16'h0ff0); // R10 stack pointer load
    wr_reg(4'd12, 16'h5555); // unused select, must change nothing

    for (int w = 0; w < 3; w++) begin
      wait_cfg = w;
      for (int m = 0; m < 16; m++)
        for (int ai = 0; ai < 4; ai++)
          for (int r = 0; r < 8; r++) begin
            run(4'(m), avals[ai], 3'(r), avals[ai] ^ 16'h5555, 1'b0);
            if (m == 7) run(4'd3, 16'h0, 3'(r), 16'h0, 1'b0); // R9 incremented value
          end
    end

    // R13: start pulses during a busy direct read
    wait_cfg = 3;
    run(4'd1, 16'h0400, 3'd0, 16'h0, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(done === 1'b0, "R13", "extra done", done, 0);
      chk(operand === memf(16'h0400), "R13", "operand kept", operand, memf(16'h0400));
    end
    // R12 long wait on indirect
    wait_cfg = 7;
    run(4'd2, 16'h0777, 3'd1, 16'h0, 1'b0);
    run(4'd8, 16'hbeef, 3'd5, 16'h0, 1'b0); // R10 with unrelated fields
    summary();
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    summary();
  end

endmodule